// File: doc/BRIEF.md
# Jittered Switching Oscillator with Frequency Foldback

This block is the timing heart of a fixed-frequency current-mode switching controller. It produces a train of cycle-start pulses that set the power switch, together with a terminate pulse that ends the on-time once the allowed share of the period has elapsed. The nominal rate is one of two options picked by a select input. The period is spread by a slow triangular modulation of about plus or minus six percent, which softens the conducted emission spectrum.

At light load, a digitized feedback code lowers the switching rate. When the code falls below a start breakpoint, the period stretches linearly from its nominal length. It reaches the period of the minimum frequency at an end breakpoint and stays there for lower codes. The triangular spreading stays active while the rate is folded back. When the controller signals that it is running at maximum duty, the foldback is overridden and the nominal period is used. A skip flag stops new cycles from starting. Every length is an integer number of clock counts. The period and the duty point are computed only at a cycle boundary, so a cycle that has begun always finishes with the lengths it started with.

The cycle control is a three-state machine:
- IDLE: no cycle is running. It moves to ON when skip is low.
- ON: the on-time window is open. It moves to OFF when the count reaches the duty point.
- OFF: the remainder of the period. At the last count it moves to ON when skip is low (a restart) or to IDLE when skip is high (a skip stop).

Top module: `pwm_dither_osc`

## Requirements
- R1: While reset is asserted and until the first cycle begins, cyc_start_o and duty_stop_o are 0 and period_o is 0.
- R2: With feedback at or above FB_START and the dither at its centre, the period is floor(CLK_HZ/LO_HZ) clocks when freq_sel_i=0 and floor(CLK_HZ/HI_HZ) clocks when freq_sel_i=1.
- R3: duty_stop_o pulses for one clock exactly floor(P*DUTY_PCT/100) clocks after the cyc_start_o of a cycle of period P. DUTY_PCT is 80 by default.
- R4: The dither position d is a signed step counter that starts at 0 and rises first. It moves by one every floor(CLK_HZ/(MOD_HZ*4*JIT_DEPTH)) clocks and turns around at +JIT_DEPTH and -JIT_DEPTH. The period is the base period plus floor(base*|d|*JIT_PCT/(100*JIT_DEPTH)) for d>0, minus that amount for d<0.
- R5: For FB_END < fb < FB_START, the base period is nom + floor((Pmin-nom)*(FB_START-fb)/(FB_START-FB_END)), where Pmin=floor(CLK_HZ/FLOOR_HZ). For fb <= FB_END the base period is Pmin.
- R6: The dither offset of R4 is applied to the folded base period as well, so that a constant folded feedback gives periods both above and below that base.
- R7: When at_max_duty_i is 1 at a cycle boundary, the base period is nom, whatever the feedback.
- R8: If skip_i is 1 at the last clock of a period, no cyc_start_o follows. When skip_i then reads 0 at a clock edge, cyc_start_o is high in the very next cycle.
- R9: period_o and the duty point are latched only when a cycle starts. Changes of feedback, select, max-duty or dither during a cycle do not alter that cycle.
- R10: Between restarts, the next cyc_start_o comes exactly period_o clocks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel_i | input | 1 | Nominal rate select: 0 = low option, 1 = high option |
| fb_code_i | input | FB_W | Unsigned digitized feedback level |
| skip_i | input | 1 | Suppresses new cycle starts |
| at_max_duty_i | input | 1 | Controller is at maximum duty; forces the nominal period |
| cyc_start_o | output | 1 | One-clock pulse at the start of each cycle |
| duty_stop_o | output | 1 | One-clock pulse at the maximum-duty point |
| period_o | output | PER_W | Length of the current cycle in clocks |

## Verification
The bench builds the block with CLK_HZ=10,000,000, MOD_HZ=5,000 and JIT_DEPTH=6. This gives nominal periods of 153 and 100 clocks, a floor period of 370 clocks and a dither step every 83 clocks. A full triangle then takes about two thousand clocks, so one run covers several modulation sweeps under each feedback setting. The short periods also make many cycle boundaries reachable, including the skip stop and restart, the max-duty override at the floor code, and feedback that toggles in the middle of a cycle.

// File: rtl/osc_pkg.sv
package osc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } osc_state_e;

endpackage

// File: rtl/osc_tri_dither.sv
module osc_tri_dither #(
    parameter int DEPTH    = 8,
    parameter int STEP_DIV = 25000,
    parameter int MW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [MW-1:0] mag_o,
    output logic          neg_o
);

    localparam int SW  = MW + 1;
    localparam int TKW = ($clog2(STEP_DIV) > 0) ? $clog2(STEP_DIV) : 1;

    logic [TKW-1:0]       tk_q;
    logic signed [SW-1:0] pos_q;
    logic                 up_q;
    logic                 tick;

    assign tick = (tk_q == TKW'(STEP_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q  <= '0;
            pos_q <= '0;
            up_q  <= 1'b1;
        end else begin
            tk_q <= tick ? '0 : tk_q + TKW'(1);
            if (tick) begin
                if (up_q) begin
                    if (pos_q == SW'(DEPTH)) begin
                        up_q  <= 1'b0;
                        pos_q <= pos_q - SW'(1);
                    end else begin
                        pos_q <= pos_q + SW'(1);
                    end
                end else begin
                    if (pos_q == SW'(-DEPTH)) begin
                        up_q  <= 1'b1;
                        pos_q <= pos_q + SW'(1);
                    end else begin
                        pos_q <= pos_q - SW'(1);
                    end
                end
            end
        end
    end

    assign neg_o = pos_q[SW-1];
    assign mag_o = pos_q[SW-1] ? MW'(-pos_q) : MW'(pos_q);

    // R4
    dither_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));

    // R4
    dither_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((pos_q == $past(pos_q) + SW'(1)) || (pos_q == $past(pos_q) - SW'(1))));

    // R4
    dither_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mag_o <= MW'(DEPTH));

endmodule

// File: rtl/osc_period_calc.sv
module osc_period_calc #(
    parameter int unsigned FB_W     = 10,
    parameter int unsigned P_LO     = 1538,
    parameter int unsigned P_HI     = 1000,
    parameter int unsigned P_FLOOR  = 3703,
    parameter int unsigned FB_START = 409,
    parameter int unsigned FB_END   = 276,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned JIT_PCT  = 6,
    parameter int unsigned DUTY_PCT = 80,
    parameter int          MW       = 4,
    parameter int          PW       = 16
) (
    input  logic            freq_sel_i,
    input  logic [FB_W-1:0] fb_i,
    input  logic            at_max_i,
    input  logic [MW-1:0]   mag_i,
    input  logic            neg_i,
    output logic [PW-1:0]   per_o,
    output logic [PW-1:0]   lim_o
);

    localparam int unsigned SPAN = FB_START - FB_END;

    int unsigned nom;
    int unsigned fbv;
    int unsigned base;
    int unsigned off;
    int unsigned per;

    always_comb begin
        nom = freq_sel_i ? P_HI : P_LO;
        fbv = 32'(fb_i);
        if (at_max_i || fbv >= FB_START) begin
            base = nom;
        end else if (fbv <= FB_END) begin
            base = P_FLOOR;
        end else begin
            base = nom + ((P_FLOOR - nom) * (FB_START - fbv)) / SPAN;
        end
        off   = (base * 32'(mag_i) * JIT_PCT) / (100 * DEPTH);
        per   = neg_i ? base - off : base + off;
        per_o = PW'(per);
        lim_o = PW'((per * DUTY_PCT) / 100);
    end

endmodule

// File: rtl/osc_cycle_fsm.sv
module osc_cycle_fsm
    import osc_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          skip_i,
    input  logic [PW-1:0] per_next_i,
    input  logic [PW-1:0] lim_next_i,
    output logic          cyc_start_o,
    output logic          duty_stop_o,
    output logic [PW-1:0] per_o
);

    osc_state_e    st_q, st_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] per_q, per_d;
    logic [PW-1:0] lim_q, lim_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            per_q <= '0;
            lim_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            per_q <= per_d;
            lim_q <= lim_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + PW'(1);
        per_d = per_q;
        lim_d = lim_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!skip_i) begin
                    st_d  = ST_ON;
                    per_d = per_next_i;
                    lim_d = lim_next_i;
                end
            end
            ST_ON: begin
                if (cnt_q == lim_q - PW'(1)) begin
                    st_d = ST_OFF;
                end
            end
            ST_OFF: begin
                if (cnt_q == per_q - PW'(1)) begin
                    cnt_d = '0;
                    if (skip_i) begin
                        st_d = ST_IDLE;
                    end else begin
                        st_d  = ST_ON;
                        per_d = per_next_i;
                        lim_d = lim_next_i;
                    end
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        cyc_start_o = (st_q == ST_ON)  && (cnt_q == '0);
        duty_stop_o = (st_q == ST_OFF) && (cnt_q == lim_q);
        per_o       = per_q;
    end

    // R9
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !cyc_start_o) |-> $stable(per_q));

    // R8
    skip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && cnt_q == per_q - PW'(1) && skip_i) |=> (st_q == ST_IDLE && !cyc_start_o));

    // R3
    duty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_stop_o |-> ($past(st_q) == ST_ON));

endmodule

// File: rtl/pwm_dither_osc.sv
module pwm_dither_osc #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned LO_HZ     = 65_000,
    parameter int unsigned HI_HZ     = 100_000,
    parameter int unsigned FLOOR_HZ  = 27_000,
    parameter int unsigned MOD_HZ    = 125,
    parameter int unsigned JIT_DEPTH = 8,
    parameter int unsigned JIT_PCT   = 6,
    parameter int unsigned DUTY_PCT  = 80,
    parameter int unsigned FB_W      = 10,
    parameter int unsigned FB_START  = 409,
    parameter int unsigned FB_END    = 276,
    parameter int          PER_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_sel_i,
    input  logic [FB_W-1:0]  fb_code_i,
    input  logic             skip_i,
    input  logic             at_max_duty_i,
    output logic             cyc_start_o,
    output logic             duty_stop_o,
    output logic [PER_W-1:0] period_o
);

    localparam int unsigned P_LO     = CLK_HZ / LO_HZ;
    localparam int unsigned P_HI     = CLK_HZ / HI_HZ;
    localparam int unsigned P_FLOOR  = CLK_HZ / FLOOR_HZ;
    localparam int unsigned STEP_DIV = CLK_HZ / (MOD_HZ * 4 * JIT_DEPTH);
    localparam int          MW       = $clog2(JIT_DEPTH + 1);
    localparam int unsigned MIN_P    = P_HI - (P_HI * JIT_PCT) / 100 - 1;
    localparam int unsigned MAX_P    = P_FLOOR + (P_FLOOR * JIT_PCT) / 100 + 1;

    logic [MW-1:0]    mag;
    logic             neg;
    logic [PER_W-1:0] per_next;
    logic [PER_W-1:0] lim_next;

    generate
        if (JIT_PCT > 0) begin : g_dither
            osc_tri_dither #(
                .DEPTH    (int'(JIT_DEPTH)),
                .STEP_DIV (int'(STEP_DIV)),
                .MW       (MW)
            ) u_dither (
                .clk   (clk),
                .rst_n (rst_n),
                .mag_o (mag),
                .neg_o (neg)
            );
        end else begin : g_flat
            assign mag = '0;
            assign neg = 1'b0;
        end
    endgenerate

    osc_period_calc #(
        .FB_W     (FB_W),
        .P_LO     (P_LO),
        .P_HI     (P_HI),
        .P_FLOOR  (P_FLOOR),
        .FB_START (FB_START),
        .FB_END   (FB_END),
        .DEPTH    (JIT_DEPTH),
        .JIT_PCT  (JIT_PCT),
        .DUTY_PCT (DUTY_PCT),
        .MW       (MW),
        .PW       (PER_W)
    ) u_calc (
        .freq_sel_i (freq_sel_i),
        .fb_i       (fb_code_i),
        .at_max_i   (at_max_duty_i),
        .mag_i      (mag),
        .neg_i      (neg),
        .per_o      (per_next),
        .lim_o      (lim_next)
    );

    osc_cycle_fsm #(
        .PW (PER_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .skip_i      (skip_i),
        .per_next_i  (per_next),
        .lim_next_i  (lim_next),
        .cyc_start_o (cyc_start_o),
        .duty_stop_o (duty_stop_o),
        .per_o       (period_o)
    );

    // R10
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |-> (period_o >= PER_W'(MIN_P) && period_o <= PER_W'(MAX_P)));

endmodule

// File: tb/pwm_dither_osc_test.sv
module pwm_dither_osc_test;

    localparam int B_CLK   = 10_000_000;
    localparam int B_MOD   = 5_000;
    localparam int B_DEPTH = 6;
    localparam int B_FBS   = 409;
    localparam int B_FBE   = 276;
    localparam int NOM_LO  = B_CLK / 65_000;
    localparam int NOM_HI  = B_CLK / 100_000;
    localparam int PMIN    = B_CLK / 27_000;
    localparam int STEP    = B_CLK / (B_MOD * 4 * B_DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_sel = 1'b0;
    logic [9:0]  fb = 10'd1000;
    logic        skip = 1'b1;
    logic        at_max = 1'b0;
    logic        cs, ds;
    logic [15:0] per;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // bench-side reference state
    int m_active = 0, m_pos = 0, m_per = 0, m_lim = 0;
    int m_d = 0, m_up = 1, m_tk = 0;
    int st_min, st_max, st_starts;

    always #5 clk = ~clk;

    pwm_dither_osc #(
        .CLK_HZ (B_CLK), .MOD_HZ (B_MOD), .JIT_DEPTH (B_DEPTH),
        .FB_START (B_FBS), .FB_END (B_FBE)
    ) uut (
        .clk (clk), .rst_n (rst_n), .freq_sel_i (freq_sel), .fb_code_i (fb),
        .skip_i (skip), .at_max_duty_i (at_max),
        .cyc_start_o (cs), .duty_stop_o (ds), .period_o (per)
    );

    function automatic int base_len(int sel, int f, int mx);
        int nom = sel ? NOM_HI : NOM_LO;
        if (mx != 0 || f >= B_FBS) return nom;
        if (f <= B_FBE) return PMIN;
        return nom + ((PMIN - nom) * (B_FBS - f)) / (B_FBS - B_FBE);
    endfunction

    function automatic int full_len(int sel, int f, int mx, int d);
        int b = base_len(sel, f, mx);
        int a = d < 0 ? -d : d;
        int o = (b * a * 6) / (100 * B_DEPTH);
        return d < 0 ? b - o : b + o;
    endfunction

    task automatic begin_cycle();
        m_active = 1;
        m_pos = 0;
        m_per = full_len(int'(freq_sel), int'(fb), int'(at_max), m_d);
        m_lim = (m_per * 80) / 100;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_pos = 0; m_per = 0; m_lim = 0;
            m_d = 0; m_up = 1; m_tk = 0;
        end else begin
            if (m_active == 0) begin
                if (!skip) begin_cycle();
            end else if (m_pos == m_per - 1) begin
                if (skip) begin m_active = 0; m_pos = 0; end
                else begin_cycle();
            end else begin
                m_pos++;
            end
            if (m_tk == STEP - 1) begin
                m_tk = 0;
                if (m_up != 0) begin
                    if (m_d == B_DEPTH) begin m_up = 0; m_d--; end else m_d++;
                end else begin
                    if (m_d == -B_DEPTH) begin m_up = 1; m_d++; end else m_d--;
                end
            end else begin
                m_tk++;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            int e_cs, e_ds, e_per;
            e_cs  = (m_active != 0 && m_pos == 0) ? 1 : 0;
            e_ds  = (m_active != 0 && m_pos == m_lim) ? 1 : 0;
            e_per = m_per;
            total++;
            if (int'(cs) != e_cs || int'(ds) != e_ds || int'(per) != e_per) begin
                bad++;
                $display("FAIL %s t=%0t cs/ds/per actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                         cur_req, $time, cs, ds, per, e_cs, e_ds, e_per);
            end
            if (cs) begin
                st_starts++;
                if (int'(per) < st_min) st_min = int'(per);
                if (int'(per) > st_max) st_max = int'(per);
            end
        end
    end

    task automatic run_phase(string tag, int cycles);
        cur_req = tag;
        st_min = 1 << 30; st_max = 0; st_starts = 0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic expect_true(string tag, bit ok, int act, int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        expect_true("R1 reset outputs", cs == 0 && ds == 0 && per == 0, int'(per), 0);
        rst_n = 1'b1;
        run_phase("R1", 20);
        expect_true("R1 idle under skip", st_starts == 0, st_starts, 0);

        // R2/R3/R4/R10: nominal low option across dither sweeps
        skip = 1'b0;
        run_phase("R2 R3 R4 R10 low", 4000);
        expect_true("R4 dither upper", st_max > NOM_LO, st_max, NOM_LO + 1);
        expect_true("R4 dither lower", st_min < NOM_LO, st_min, NOM_LO - 1);

        // R2: high option
        freq_sel = 1'b1;
        run_phase("R2 high", 3000);
        expect_true("R2 high upper bound", st_max <= full_len(1, 1000, 0, B_DEPTH),
                    st_max, full_len(1, 1000, 0, B_DEPTH));

        // R5/R6: linear foldback region with dither
        freq_sel = 1'b0;
        fb = 10'd340;
        run_phase("R5 R6 fold", 4000);
        expect_true("R6 fold dither above", st_max > base_len(0, 340, 0), st_max, base_len(0, 340, 0) + 1);
        expect_true("R6 fold dither below", st_min < base_len(0, 340, 0), st_min, base_len(0, 340, 0) - 1);

        // R5: floor
        fb = 10'd200;
        run_phase("R5 floor", 4000);
        expect_true("R5 floor reached", st_max >= PMIN, st_max, PMIN);

        // R7: max duty overrides foldback
        at_max = 1'b1;
        run_phase("R7 maxduty", 3000);
        expect_true("R7 nominal under max duty", st_max <= full_len(0, 1000, 0, B_DEPTH),
                    st_max, full_len(0, 1000, 0, B_DEPTH));
        at_max = 1'b0;

        // R8: skip stops new starts, restart after release
        fb = 10'd1000;
        skip = 1'b1;
        run_phase("R8 skip", 600);
        run_phase("R8 skip hold", 400);
        expect_true("R8 no starts while skipping", st_starts == 0, st_starts, 0);
        skip = 1'b0;
        run_phase("R8 restart", 1000);
        expect_true("R8 restarts", st_starts > 0, st_starts, 1);

        // R9: feedback changing mid-cycle
        cur_req = "R9 midcycle";
        for (int i = 0; i < 80; i++) begin
            fb = (i % 2 != 0) ? 10'd300 : 10'd1000;
            freq_sel = (i % 3 == 0);
            repeat (37) @(negedge clk);
        end
        expect_true("R9 run completed", 1'b1, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule